// File: doc/BRIEF.md
# UART Receive/Transmit Interrupt and Line Status Controller

This block generates the interrupt request, the interrupt identification code and the 8-bit line status word for a UART with a 64-entry FIFO in each direction. The FIFO storage, the serial shifters, the baud generator and the bus decoding sit outside it. It sees them through a handful of inputs: the receive FIFO fill count, the transmit FIFO and transmit shifter empty flags, pulses for erroneous characters that enter or leave the receive FIFO, and the error flags of each new head character. Strobes mark the reads of the identification and status registers.

The receive interrupt is level-driven. It is raised while the receive fill count is at or above a trigger level chosen by a 2-bit field, and it drops by itself once the count falls below that level. No read is needed to clear it. The transmit interrupt is raised when the transmit FIFO is empty. A read of the identification register while it shows the transmit code acknowledges that interrupt, and it stays quiet until the transmit FIFO empties again. When the FIFO is enabled and all four enable bits are zero, the block is in polled mode. No interrupt is driven, but the status word keeps tracking the FIFOs.

The interrupt side is a three-state machine. S_QUIET means nothing is pending. S_RXDATA means received data is available and takes priority. S_THRE means the transmit holding side is empty. Every state can move to every other state, and it does so each clock:
- Any state goes to S_RXDATA when the receive condition holds.
- Otherwise, any state goes to S_THRE when the armed transmit condition holds.
- Otherwise, any state goes to S_QUIET.

Top module: `uart_irq_status`

## Requirements
- R1: With `fifo_en`=1 and `ier[0]`=1, one clock after `rx_count` is at or above the trigger level, `irq`=1 and `iir_code`=4'b0100.
- R2: One clock after `rx_count` falls below the trigger level, `iir_code` leaves 4'b0100. No register read is involved.
- R3: The trigger level is chosen by `trig_sel`: 0 selects 1, 1 selects 16, 2 selects 32 and 3 selects 56 entries.
- R4: `lsr[0]` is 1 in the same cycle that `rx_count` is nonzero, and 0 when `rx_count` is zero.
- R5: With `fifo_en`=1 and `ier`=0, `irq` stays 0 and `iir_code` stays 4'b0001. The `lsr` bits keep following their inputs.
- R6: `lsr[4:1]` are sticky copies of `head_err[3:0]`, in the order overrun, parity, framing, break from bit 1 to bit 4. They are ORed in one clock after a `head_new` pulse and cleared one clock after `lsr_rd`. A new set in the same cycle as a read wins.
- R7: `lsr[5]` equals `tx_fifo_empty`. `lsr[6]` is 1 only when both `tx_fifo_empty` and `tx_shift_empty` are 1.
- R8: `lsr[7]` is 1 while at least one erroneous character remains in the receive FIFO. The count goes up on `err_in` and down on `err_out`, and it is visible one clock later.
- R9: With `ier[1]`=1, an empty transmit FIFO and the transmit interrupt armed, `irq`=1 and `iir_code`=4'b0010 one clock later. The interrupt is armed out of reset.
- R10: When the receive and transmit conditions hold together, `iir_code` shows 4'b0100.
- R11: An `iir_rd` while `iir_code`=4'b0010 disarms the transmit interrupt. It is re-armed only when `tx_fifo_empty` rises from 0 to 1.
- R12: With `fifo_en`=0, the receive interrupt uses a level of 1 whatever `trig_sel` holds.
- R13: `iir_code` is 4'b0001 exactly when `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | FIFO mode enable |
| ier | input | 4 | Interrupt enables; bit 0 receive, bit 1 transmit |
| trig_sel | input | 2 | Receive trigger level select |
| rx_count | input | 7 | Receive FIFO fill count, 0 to 64 |
| err_in | input | 1 | Pulse: an erroneous character entered the receive FIFO |
| err_out | input | 1 | Pulse: an erroneous character left the receive FIFO |
| head_new | input | 1 | Pulse: a new character reached the FIFO head |
| head_err | input | 4 | Error flags of the new head character |
| tx_fifo_empty | input | 1 | Transmit FIFO empty |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| iir_rd | input | 1 | Identification register read strobe |
| lsr_rd | input | 1 | Line status read strobe |
| irq | output | 1 | Interrupt request |
| iir_code | output | 4 | Interrupt identification code |
| lsr | output | 8 | Line status word |

## Verification
Two events can land in the same clock: the acknowledge of the transmit interrupt by an identification read, and the receive count reaching its trigger. The bench sets up S_THRE with both interrupts enabled. It then drives `iir_rd` together with a step of `rx_count` up to the level. It expects 4'b0100 on the next clock and 4'b0001 once the count drops again, which shows that the read both yielded to the higher priority and disarmed the transmit side. A second case is also checked: a status read that meets a new head error in the same cycle must keep the new error bit.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [1:0] {
        S_QUIET  = 2'd0,
        S_RXDATA = 2'd1,
        S_THRE   = 2'd2
    } irq_state_t;

    localparam logic [3:0] CODE_NONE = 4'b0001;
    localparam logic [3:0] CODE_RX   = 4'b0100;
    localparam logic [3:0] CODE_THRE = 4'b0010;

endpackage

// File: rtl/uart_rx_trig.sv
module uart_rx_trig #(
    parameter int CNT_W = 7,
    parameter int LVL0  = 1,
    parameter int LVL1  = 16,
    parameter int LVL2  = 32,
    parameter int LVL3  = 56
) (
    input  logic             fifo_en,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] rx_count,
    output logic             at_level
);
    logic [CNT_W-1:0] level;

    always_comb begin
        if (!fifo_en) begin
            level = CNT_W'(1);
        end else begin
            unique case (trig_sel)
                2'd0: level = CNT_W'(LVL0);
                2'd1: level = CNT_W'(LVL1);
                2'd2: level = CNT_W'(LVL2);
                default: level = CNT_W'(LVL3);
            endcase
        end
    end

    assign at_level = (rx_count >= level);
endmodule

// File: rtl/uart_err_track.sv
module uart_err_track #(
    parameter int CNT_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       err_in,
    input  logic       err_out,
    input  logic       head_new,
    input  logic [3:0] head_err,
    input  logic       lsr_rd,
    output logic [3:0] sticky,
    output logic       any_bad
);
    logic [CNT_W-1:0] bad_cnt;
    logic [3:0]       sticky_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bad_cnt  <= '0;
            sticky_q <= '0;
        end else begin
            if (err_in && !err_out)
                bad_cnt <= bad_cnt + CNT_W'(1);
            else if (err_out && !err_in && bad_cnt != '0)
                bad_cnt <= bad_cnt - CNT_W'(1);
            sticky_q <= (lsr_rd ? 4'b0000 : sticky_q) | (head_new ? head_err : 4'b0000);
        end
    end

    assign sticky  = sticky_q;
    assign any_bad = (bad_cnt != '0);
endmodule

// File: rtl/uart_irq_fsm.sv
module uart_irq_fsm
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_hit,
    input  logic       thre_en,
    input  logic       tx_fifo_empty,
    input  logic       iir_rd,
    output logic       irq,
    output logic [3:0] iir_code
);
    irq_state_t state, state_nxt;
    logic arm, arm_nxt, tx_prev, tx_rise, thre_hit;

    assign tx_rise  = tx_fifo_empty && !tx_prev;
    assign arm_nxt  = tx_rise ? 1'b1 : ((iir_rd && state == S_THRE) ? 1'b0 : arm);
    assign thre_hit = thre_en && tx_fifo_empty && arm_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_QUIET: begin
                if (rx_hit)        state_nxt = S_RXDATA;
                else if (thre_hit) state_nxt = S_THRE;
            end
            S_RXDATA: begin
                if (!rx_hit)       state_nxt = thre_hit ? S_THRE : S_QUIET;
            end
            S_THRE: begin
                if (rx_hit)        state_nxt = S_RXDATA;
                else if (!thre_hit) state_nxt = S_QUIET;
            end
            default:               state_nxt = S_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_QUIET;
            arm     <= 1'b1;
            tx_prev <= 1'b1;
        end else begin
            state   <= state_nxt;
            arm     <= arm_nxt;
            tx_prev <= tx_fifo_empty;
        end
    end

    always_comb begin
        unique case (state)
            S_RXDATA: begin irq = 1'b1; iir_code = CODE_RX;   end
            S_THRE:   begin irq = 1'b1; iir_code = CODE_THRE; end
            default:  begin irq = 1'b0; iir_code = CODE_NONE; end
        endcase
    end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status #(
    parameter int DEPTH = 64,
    parameter int LVL0  = 1,
    parameter int LVL1  = 16,
    parameter int LVL2  = 32,
    parameter int LVL3  = 56,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [3:0]       ier,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             err_in,
    input  logic             err_out,
    input  logic             head_new,
    input  logic [3:0]       head_err,
    input  logic             tx_fifo_empty,
    input  logic             tx_shift_empty,
    input  logic             iir_rd,
    input  logic             lsr_rd,
    output logic             irq,
    output logic [3:0]       iir_code,
    output logic [7:0]       lsr
);
    logic at_level, polled, rx_hit, thre_en, any_bad;
    logic [3:0] sticky;

    assign polled  = fifo_en && (ier == 4'b0000);
    assign rx_hit  = ier[0] && !polled && at_level;
    assign thre_en = ier[1] && !polled;

    uart_rx_trig #(
        .CNT_W(CNT_W), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
    ) u_trig (
        .fifo_en (fifo_en),
        .trig_sel(trig_sel),
        .rx_count(rx_count),
        .at_level(at_level)
    );

    uart_err_track #(.CNT_W(CNT_W)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .err_in  (err_in),
        .err_out (err_out),
        .head_new(head_new),
        .head_err(head_err),
        .lsr_rd  (lsr_rd),
        .sticky  (sticky),
        .any_bad (any_bad)
    );

    uart_irq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_hit       (rx_hit),
        .thre_en      (thre_en),
        .tx_fifo_empty(tx_fifo_empty),
        .iir_rd       (iir_rd),
        .irq          (irq),
        .iir_code     (iir_code)
    );

    assign lsr = {any_bad, tx_fifo_empty && tx_shift_empty, tx_fifo_empty,
                  sticky, rx_count != '0};
endmodule

// File: rtl/uart_irq_status_chk.sv
module uart_irq_status_chk #(
    parameter int CNT_W = 7,
    parameter int LVL3  = 56
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic [3:0]       ier,
    input logic [1:0]       trig_sel,
    input logic [CNT_W-1:0] rx_count,
    input logic             err_out,
    input logic             tx_fifo_empty,
    input logic             iir_rd,
    input logic             irq,
    input logic [3:0]       iir_code,
    input logic [7:0]       lsr
);
    AST_RX_TOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && ier[0] && trig_sel == 2'd3 && rx_count >= CNT_W'(LVL3)) |=> (iir_code == 4'b0100)); // R1
    AST_RX_LEVEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && rx_count == '0) |=> (iir_code != 4'b0100)); // R2
    AST_POLLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && ier == 4'b0000) |=> !irq); // R5
    AST_TX_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        lsr[6] |-> lsr[5]); // R7
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr[7] && !err_out) |=> lsr[7]); // R8
    AST_THRE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && iir_code == 4'b0010 && $stable(tx_fifo_empty)) |=> (iir_code != 4'b0010)); // R11
    AST_IRQ_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (iir_code != 4'b0001)); // R13
endmodule

bind uart_irq_status uart_irq_status_chk #(.CNT_W(CNT_W), .LVL3(LVL3)) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ier(ier), .trig_sel(trig_sel),
    .rx_count(rx_count), .err_out(err_out), .tx_fifo_empty(tx_fifo_empty),
    .iir_rd(iir_rd), .irq(irq), .iir_code(iir_code), .lsr(lsr)
);

// File: tb/uart_irq_status_bench.sv
module uart_irq_status_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b1;
    logic [3:0] ier = 4'b0000;
    logic [1:0] trig_sel = 2'd0;
    logic [6:0] rx_count = '0;
    logic       err_in = 1'b0, err_out = 1'b0, head_new = 1'b0;
    logic [3:0] head_err = 4'b0000;
    logic       tx_fifo_empty = 1'b1, tx_shift_empty = 1'b1;
    logic       iir_rd = 1'b0, lsr_rd = 1'b0;
    logic       irq;
    logic [3:0] iir_code;
    logic [7:0] lsr;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    uart_irq_status u_uart_irq_status (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ier(ier), .trig_sel(trig_sel),
        .rx_count(rx_count), .err_in(err_in), .err_out(err_out), .head_new(head_new),
        .head_err(head_err), .tx_fifo_empty(tx_fifo_empty), .tx_shift_empty(tx_shift_empty),
        .iir_rd(iir_rd), .lsr_rd(lsr_rd), .irq(irq), .iir_code(iir_code), .lsr(lsr)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (2) tick();
        rst_n = 1'b1;
        tick();
        chk("R13 reset irq", {7'd0, irq}, 8'h00);
        chk("R13 reset code", {4'd0, iir_code}, 8'h01);
        chk("R7 reset lsr", lsr, 8'h60);
    endtask

    task automatic t_trigger();
        int lv [4] = '{1, 16, 32, 56};
        ier = 4'b0001;
        for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            rx_count = 7'(lv[s] - 1);
            tick();
            chk("R3 below level", {4'd0, iir_code}, 8'h01);
            rx_count = 7'(lv[s]);
            tick();
            chk("R1 at level code", {4'd0, iir_code}, 8'h04);
            chk("R1 at level irq", {7'd0, irq}, 8'h01);
            rx_count = 7'(lv[s] - 1);
            tick();
            chk("R2 drop clears", {4'd0, iir_code}, 8'h01);
        end
        rx_count = 7'd64;
        tick();
        chk("R3 full fifo", {4'd0, iir_code}, 8'h04);
        rx_count = '0;
        ier = 4'b0000;
        trig_sel = 2'd0;
        tick();
    endtask

    task automatic t_data_ready();
        rx_count = 7'd0; #1;
        chk("R4 empty", {7'd0, lsr[0]}, 8'h00);
        rx_count = 7'd1; #1;
        chk("R4 one", {7'd0, lsr[0]}, 8'h01);
        rx_count = 7'd64; #1;
        chk("R4 full", {7'd0, lsr[0]}, 8'h01);
        rx_count = 7'd0; #1;
        chk("R4 emptied", {7'd0, lsr[0]}, 8'h00);
        tick();
    endtask

    task automatic t_polled();
        ier = 4'b0000;
        trig_sel = 2'd0;
        rx_count = 7'd60;
        tick();
        chk("R5 polled irq", {7'd0, irq}, 8'h00);
        chk("R5 polled code", {4'd0, iir_code}, 8'h01);
        chk("R5 polled lsr0", {7'd0, lsr[0]}, 8'h01);
        err_in = 1'b1; tick(); err_in = 1'b0;
        chk("R5 polled lsr7", {7'd0, lsr[7]}, 8'h01);
        err_out = 1'b1; tick(); err_out = 1'b0;
        rx_count = '0;
        tick();
    endtask

    task automatic t_errors();
        head_err = 4'b0101; head_new = 1'b1; tick(); head_new = 1'b0;
        chk("R6 first head", {4'd0, lsr[4:1]}, 8'h05);
        head_err = 4'b1000; head_new = 1'b1; tick(); head_new = 1'b0;
        chk("R6 accumulate", {4'd0, lsr[4:1]}, 8'h0d);
        lsr_rd = 1'b1; tick(); lsr_rd = 1'b0;
        chk("R6 read clears", {4'd0, lsr[4:1]}, 8'h00);
        head_err = 4'b0010; head_new = 1'b1; lsr_rd = 1'b1; tick();
        head_new = 1'b0; lsr_rd = 1'b0;
        chk("R6 set wins over read", {4'd0, lsr[4:1]}, 8'h02);
        lsr_rd = 1'b1; tick(); lsr_rd = 1'b0;
        chk("R6 clear again", {4'd0, lsr[4:1]}, 8'h00);
    endtask

    task automatic t_tx_status();
        tx_fifo_empty = 1'b0; tx_shift_empty = 1'b0; #1;
        chk("R7 both busy", {6'd0, lsr[6:5]}, 8'h00);
        tx_fifo_empty = 1'b1; #1;
        chk("R7 shifter busy", {6'd0, lsr[6:5]}, 8'h01);
        tx_shift_empty = 1'b1; #1;
        chk("R7 all empty", {6'd0, lsr[6:5]}, 8'h03);
        tick();
    endtask

    task automatic t_err_count();
        err_in = 1'b1; tick(); tick(); err_in = 1'b0;
        chk("R8 two bad", {7'd0, lsr[7]}, 8'h01);
        err_in = 1'b1; err_out = 1'b1; tick(); err_in = 1'b0;
        chk("R8 in and out hold", {7'd0, lsr[7]}, 8'h01);
        tick(); err_out = 1'b0;
        chk("R8 one left", {7'd0, lsr[7]}, 8'h01);
        err_out = 1'b1; tick(); err_out = 1'b0;
        chk("R8 none left", {7'd0, lsr[7]}, 8'h00);
    endtask

    task automatic t_thre();
        ier = 4'b0010;
        tx_fifo_empty = 1'b0;
        tick();
        chk("R9 not empty", {4'd0, iir_code}, 8'h01);
        tx_fifo_empty = 1'b1;
        tick();
        chk("R9 empty code", {4'd0, iir_code}, 8'h02);
        chk("R9 empty irq", {7'd0, irq}, 8'h01);
        iir_rd = 1'b1; tick(); iir_rd = 1'b0;
        chk("R11 read acks", {4'd0, iir_code}, 8'h01);
        tick();
        chk("R11 stays acked", {4'd0, iir_code}, 8'h01);
        tx_fifo_empty = 1'b0; tick();
        tx_fifo_empty = 1'b1; tick();
        chk("R11 re-armed", {4'd0, iir_code}, 8'h02);
    endtask

    task automatic t_priority();
        ier = 4'b0011;
        trig_sel = 2'd0;
        rx_count = 7'd1;
        tick();
        chk("R10 rx over thre", {4'd0, iir_code}, 8'h04);
        rx_count = 7'd0;
        tick();
        chk("R10 back to thre", {4'd0, iir_code}, 8'h02);
        iir_rd = 1'b1; rx_count = 7'd1; tick(); iir_rd = 1'b0;
        chk("R10 collision rx", {4'd0, iir_code}, 8'h04);
        rx_count = 7'd0; tick();
        chk("R11 collision disarmed", {4'd0, iir_code}, 8'h01);
        ier = 4'b0000;
        tick();
    endtask

    task automatic t_nofifo();
        fifo_en = 1'b0;
        ier = 4'b0001;
        trig_sel = 2'd3;
        rx_count = 7'd1;
        tick();
        chk("R12 no fifo level one", {4'd0, iir_code}, 8'h04);
        rx_count = 7'd0;
        tick();
        chk("R12 no fifo empty", {4'd0, iir_code}, 8'h01);
        fifo_en = 1'b1;
        ier = 4'b0000;
        tick();
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_trigger();
                t_data_ready();
                t_polled();
                t_errors();
                t_tx_status();
                t_err_count();
                t_thre();
                t_priority();
                t_nofifo();
            end
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule